// File: doc/BRIEF.md
# Delayed-Branch Instruction Address Queue

This block keeps the addresses of the next two instructions to execute in a processor that uses delayed branching. The front entry is the instruction now executing. The back entry is the one that follows it. Each entry holds a word-aligned offset and a privilege level. When an instruction completes, the block receives one completion event. The event says whether the instruction was a taken branch, gives the branch target and its privilege, says whether the successor is to be skipped, and flags gateway branches and return-from-interruption loads. On each accepted event the queue advances and two status flags are updated. The taken-branch flag marks an instruction that sits in the delay slot of a taken branch. The nullify flag marks an instruction that must be skipped.

A branch target enters the back of the queue, not the front. The delay-slot instruction at the front therefore executes first. If a second branch sits in that slot, the first target executes on its own and the flow then moves to the second target. A gateway branch found in a delay slot is refused, and the block raises an illegal-instruction trap. The taken-branch flag (B) and the nullify flag (N) are held as the state of a four-state machine:

- `ST_SEQ`: B=0, N=0.
- `ST_DELAY`: B=1, N=0.
- `ST_NULL`: B=0, N=1.
- `ST_DELAY_NULL`: B=1, N=1.

The machine has these transitions:

- **skip**: from either N=1 state to `ST_SEQ`.
- **exec-taken**: to `ST_DELAY`, or to `ST_DELAY_NULL` when nullify is requested.
- **exec-linear**: to `ST_SEQ`, or to `ST_NULL` when nullify is requested.
- **gate-trap**: from `ST_DELAY`, holding the state.
- **rfi-load**: to the state given by the supplied flags.
- **hold**: on a stall or when no event arrives.

A third flag, X, is cleared by every executed or skipped instruction and is loaded by a return from interruption.

Top module: `iaq_delay_queue`

## Requirements
- R1: A taken branch that is not nullified and not trapped moves the old back entry to the front. The back entry becomes the target offset with bits [1:0] cleared and the target privilege. B becomes 1.
- R2: A completed non-branch moves the old back entry to the front. The back entry becomes the old back offset plus 4 with the old back privilege. B becomes 0.
- R3: When N is 1 at the event, the taken, gateway, return-from-interruption and nullify-request inputs have no effect. The queue advances as in R2, and N, B and X all become 0.
- R4: An executed instruction (taken or not) with the nullify request set leaves N at 1 for the next event. Without the request, N becomes 0. X becomes 0 in both cases.
- R5: A gateway branch while B=1 and N=0 drives `illegal_trap` high in the same cycle as the event. At that edge the queue and flags stay unchanged. With B=0, a gateway branch executes normally and `illegal_trap` stays low.
- R6: Each event is decided on the flags held before it. A taken branch inside the delay slot of a taken branch makes the first target execute alone, followed by the second target.
- R7: A return-from-interruption event with N=0 and no trap loads both entries (offsets with bits [1:0] cleared) and the B, N and X flags from the supplied values.
- R8: With `stall` high, or `done` low, the entries and flags hold their values and `illegal_trap` is low.
- R9: After reset, the front is at `RESET_VEC` and the back at `RESET_VEC`+4, both at privilege 0, and B, N and X are 0.
- R10: Stored offsets always have bits [1:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | Holds queue and flags this cycle |
| done | input | 1 | Completion event valid |
| is_taken | input | 1 | Completed instruction is a taken branch |
| is_gate | input | 1 | Completed instruction is a gateway branch |
| is_rfi | input | 1 | Completed instruction is a return from interruption |
| null_next | input | 1 | Request to skip the following instruction |
| tgt_off | input | OFF_W | Branch target offset |
| tgt_priv | input | PRIV_W | Branch target privilege |
| rfi_front_off | input | OFF_W | Front offset to load |
| rfi_front_priv | input | PRIV_W | Front privilege to load |
| rfi_back_off | input | OFF_W | Back offset to load |
| rfi_back_priv | input | PRIV_W | Back privilege to load |
| rfi_b | input | 1 | B flag to load |
| rfi_n | input | 1 | N flag to load |
| rfi_x | input | 1 | X flag to load |
| front_off | output | OFF_W | Front entry offset |
| front_priv | output | PRIV_W | Front entry privilege |
| back_off | output | OFF_W | Back entry offset |
| back_priv | output | PRIV_W | Back entry privilege |
| flag_b | output | 1 | Taken-branch flag |
| flag_n | output | 1 | Nullify flag |
| flag_x | output | 1 | X flag |
| illegal_trap | output | 1 | Gateway branch found in a delay slot |

## Verification
A wrong flag state shows at `flag_b` and `flag_n` one edge after the event that caused it. It shows again at the next event: the trap output is wrong in that same cycle, or the back entry is wrong at the edge that follows. A wrong entry update shows at once at `back_off`. It then reaches `front_off` one accepted event later, so a bad address reaches the front within two events. The bench therefore compares every port after every edge against a model and checks the trap output before each edge.

// File: rtl/iaq_pkg.sv
package iaq_pkg;
    // bit 0 = taken-branch flag, bit 1 = nullify flag
    typedef enum logic [1:0] {
        ST_SEQ        = 2'b00,
        ST_DELAY      = 2'b01,
        ST_NULL       = 2'b10,
        ST_DELAY_NULL = 2'b11
    } iaq_state_e;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'b00,
        OP_STEP   = 2'b01,
        OP_BRANCH = 2'b10,
        OP_LOAD   = 2'b11
    } iaq_op_e;
endpackage

// File: rtl/iaq_flag_fsm.sv
module iaq_flag_fsm
    import iaq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    adv,
    input  logic    is_taken,
    input  logic    is_gate,
    input  logic    is_rfi,
    input  logic    null_next,
    input  logic    rfi_b,
    input  logic    rfi_n,
    input  logic    rfi_x,
    output logic    flag_b,
    output logic    flag_n,
    output logic    flag_x,
    output logic    trap,
    output iaq_op_e op
);
    iaq_state_e state_q, state_d;
    logic       x_q, x_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEQ;
            x_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            x_q     <= x_d;
        end
    end

    always_comb begin
        state_d = state_q;
        x_d     = x_q;
        op      = OP_HOLD;
        trap    = 1'b0;
        if (adv) begin
            unique case (state_q)
                ST_NULL, ST_DELAY_NULL: begin
                    state_d = ST_SEQ;
                    x_d     = 1'b0;
                    op      = OP_STEP;
                end
                ST_SEQ, ST_DELAY: begin
                    if (is_gate && state_q == ST_DELAY) begin
                        trap = 1'b1;
                    end else if (is_rfi) begin
                        state_d = iaq_state_e'({rfi_n, rfi_b});
                        x_d     = rfi_x;
                        op      = OP_LOAD;
                    end else if (is_taken) begin
                        state_d = null_next ? ST_DELAY_NULL : ST_DELAY;
                        x_d     = 1'b0;
                        op      = OP_BRANCH;
                    end else begin
                        state_d = null_next ? ST_NULL : ST_SEQ;
                        x_d     = 1'b0;
                        op      = OP_STEP;
                    end
                end
            endcase
        end
    end

    always_comb begin
        flag_b = state_q[0];
        flag_n = state_q[1];
        flag_x = x_q;
    end

    AST_NULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && flag_n) |=> (!flag_n && !flag_b && !flag_x)); // R3
    AST_TAKEN_SETS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !flag_n && !flag_b && !is_rfi && is_taken) |=> flag_b); // R1
    AST_NULL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !flag_n && !trap && !is_rfi && null_next) |=> flag_n); // R4
    AST_TRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> ($stable(flag_b) && $stable(flag_n) && $stable(flag_x))); // R5
endmodule

// File: rtl/iaq_entry_regs.sv
module iaq_entry_regs
    import iaq_pkg::*;
#(
    parameter int                 OFF_W     = 32,
    parameter int                 PRIV_W    = 2,
    parameter logic [OFF_W-1:0]   RESET_VEC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  iaq_op_e           op,
    input  logic [OFF_W-1:0]  tgt_off,
    input  logic [PRIV_W-1:0] tgt_priv,
    input  logic [OFF_W-1:0]  ld_front_off,
    input  logic [PRIV_W-1:0] ld_front_priv,
    input  logic [OFF_W-1:0]  ld_back_off,
    input  logic [PRIV_W-1:0] ld_back_priv,
    output logic [OFF_W-1:0]  front_off,
    output logic [PRIV_W-1:0] front_priv,
    output logic [OFF_W-1:0]  back_off,
    output logic [PRIV_W-1:0] back_priv
);
    localparam int               STEP       = 4;
    localparam logic [OFF_W-1:0] STEP_V     = OFF_W'(STEP);
    localparam logic [OFF_W-1:0] ALIGN_MASK = ~(STEP_V - 1'b1);
    localparam logic [OFF_W-1:0] RST_FRONT  = RESET_VEC & ALIGN_MASK;

    logic [OFF_W-1:0]  fo_d, bo_d;
    logic [PRIV_W-1:0] fp_d, bp_d;

    always_comb begin
        fo_d = front_off;
        fp_d = front_priv;
        bo_d = back_off;
        bp_d = back_priv;
        unique case (op)
            OP_HOLD: ;
            OP_STEP: begin
                fo_d = back_off;
                fp_d = back_priv;
                bo_d = back_off + STEP_V;
                bp_d = back_priv;
            end
            OP_BRANCH: begin
                fo_d = back_off;
                fp_d = back_priv;
                bo_d = tgt_off & ALIGN_MASK;
                bp_d = tgt_priv;
            end
            OP_LOAD: begin
                fo_d = ld_front_off & ALIGN_MASK;
                fp_d = ld_front_priv;
                bo_d = ld_back_off & ALIGN_MASK;
                bp_d = ld_back_priv;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            front_off  <= RST_FRONT;
            front_priv <= '0;
            back_off   <= RST_FRONT + STEP_V;
            back_priv  <= '0;
        end else begin
            front_off  <= fo_d;
            front_priv <= fp_d;
            back_off   <= bo_d;
            back_priv  <= bp_d;
        end
    end

    AST_STEP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |=> (back_off == $past(back_off) + STEP_V && back_priv == $past(back_priv))); // R2
    AST_FRONT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP || op == OP_BRANCH) |=> (front_off == $past(back_off) && front_priv == $past(back_priv))); // R1
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (front_off[1:0] == 2'b00 && back_off[1:0] == 2'b00)); // R10
endmodule

// File: rtl/iaq_delay_queue.sv
module iaq_delay_queue
    import iaq_pkg::*;
#(
    parameter int               OFF_W     = 32,
    parameter int               PRIV_W    = 2,
    parameter logic [OFF_W-1:0] RESET_VEC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              done,
    input  logic              is_taken,
    input  logic              is_gate,
    input  logic              is_rfi,
    input  logic              null_next,
    input  logic [OFF_W-1:0]  tgt_off,
    input  logic [PRIV_W-1:0] tgt_priv,
    input  logic [OFF_W-1:0]  rfi_front_off,
    input  logic [PRIV_W-1:0] rfi_front_priv,
    input  logic [OFF_W-1:0]  rfi_back_off,
    input  logic [PRIV_W-1:0] rfi_back_priv,
    input  logic              rfi_b,
    input  logic              rfi_n,
    input  logic              rfi_x,
    output logic [OFF_W-1:0]  front_off,
    output logic [PRIV_W-1:0] front_priv,
    output logic [OFF_W-1:0]  back_off,
    output logic [PRIV_W-1:0] back_priv,
    output logic              flag_b,
    output logic              flag_n,
    output logic              flag_x,
    output logic              illegal_trap
);
    logic    adv;
    iaq_op_e op;

    assign adv = done && !stall;

    iaq_flag_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .is_taken  (is_taken),
        .is_gate   (is_gate),
        .is_rfi    (is_rfi),
        .null_next (null_next),
        .rfi_b     (rfi_b),
        .rfi_n     (rfi_n),
        .rfi_x     (rfi_x),
        .flag_b    (flag_b),
        .flag_n    (flag_n),
        .flag_x    (flag_x),
        .trap      (illegal_trap),
        .op        (op)
    );

    iaq_entry_regs #(
        .OFF_W     (OFF_W),
        .PRIV_W    (PRIV_W),
        .RESET_VEC (RESET_VEC)
    ) u_entries (
        .clk           (clk),
        .rst_n         (rst_n),
        .op            (op),
        .tgt_off       (tgt_off),
        .tgt_priv      (tgt_priv),
        .ld_front_off  (rfi_front_off),
        .ld_front_priv (rfi_front_priv),
        .ld_back_off   (rfi_back_off),
        .ld_back_priv  (rfi_back_priv),
        .front_off     (front_off),
        .front_priv    (front_priv),
        .back_off      (back_off),
        .back_priv     (back_priv)
    );

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(front_off) && $stable(back_off) && $stable(flag_b) && $stable(flag_n))); // R8
    AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_trap |=> ($stable(front_off) && $stable(back_off) && $stable(front_priv))); // R5
    AST_TRAP_COND: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_trap |-> (adv && flag_b && !flag_n && is_gate)); // R5
endmodule

// File: tb/tb_iaq_delay_queue.sv
module tb_iaq_delay_queue;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RV         = 32'h0000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall = 0, done = 0, is_taken = 0, is_gate = 0, is_rfi = 0, null_next = 0;
    logic [31:0] tgt_off = 0, rfi_front_off = 0, rfi_back_off = 0;
    logic [1:0]  tgt_priv = 0, rfi_front_priv = 0, rfi_back_priv = 0;
    logic rfi_b = 0, rfi_n = 0, rfi_x = 0;
    logic [31:0] front_off, back_off;
    logic [1:0]  front_priv, back_priv;
    logic flag_b, flag_n, flag_x, illegal_trap;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [31:0] m_fo, m_bo;
    logic [1:0]  m_fp, m_bp;
    logic        m_b, m_n, m_x;

    always #(CLK_PERIOD/2) clk = ~clk;

    iaq_delay_queue #(.OFF_W(32), .PRIV_W(2), .RESET_VEC(RV)) dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .done(done),
        .is_taken(is_taken), .is_gate(is_gate), .is_rfi(is_rfi), .null_next(null_next),
        .tgt_off(tgt_off), .tgt_priv(tgt_priv),
        .rfi_front_off(rfi_front_off), .rfi_front_priv(rfi_front_priv),
        .rfi_back_off(rfi_back_off), .rfi_back_priv(rfi_back_priv),
        .rfi_b(rfi_b), .rfi_n(rfi_n), .rfi_x(rfi_x),
        .front_off(front_off), .front_priv(front_priv),
        .back_off(back_off), .back_priv(back_priv),
        .flag_b(flag_b), .flag_n(flag_n), .flag_x(flag_x),
        .illegal_trap(illegal_trap)
    );

    function automatic logic exp_trap();
        return done && !stall && !m_n && m_b && is_gate;
    endfunction

    function automatic logic [71:0] pack_model();
        return {m_fo, m_fp, m_bo, m_bp, m_b, m_n, m_x};
    endfunction

    task automatic model_step();
        if (done && !stall) begin
            if (m_n) begin
                m_fo = m_bo; m_fp = m_bp; m_bo = m_bo + 32'd4;
                m_b = 0; m_n = 0; m_x = 0;
            end else if (is_gate && m_b) begin
                // trapped: nothing changes
            end else if (is_rfi) begin
                m_fo = rfi_front_off & ~32'd3; m_fp = rfi_front_priv;
                m_bo = rfi_back_off & ~32'd3;  m_bp = rfi_back_priv;
                m_b = rfi_b; m_n = rfi_n; m_x = rfi_x;
            end else begin
                m_fo = m_bo; m_fp = m_bp;
                if (is_taken) begin
                    m_bo = tgt_off & ~32'd3; m_bp = tgt_priv; m_b = 1;
                end else begin
                    m_bo = m_bo + 32'd4; m_b = 0;
                end
                m_n = null_next; m_x = 0;
            end
        end
    endtask

    task automatic cmp_state(input string tag);
        logic [71:0] act;
        act = {front_off, front_priv, back_off, back_priv, flag_b, flag_n, flag_x};
        checks++;
        if (act !== pack_model()) begin
            errors++;
            $display("FAIL %s state actual=%h expected=%h", tag, act, pack_model());
        end
    endtask

    // Inputs are already set shortly after a falling edge.
    task automatic cycle(input string tag);
        #1;
        checks++;
        if (illegal_trap !== exp_trap()) begin
            errors++;
            $display("FAIL %s trap actual=%b expected=%b", tag, illegal_trap, exp_trap());
        end
        model_step();
        @(negedge clk);
        cmp_state(tag);
    endtask

    task automatic set_ev(input logic d, input logic tk, input logic gt, input logic rf,
                          input logic nn, input logic [31:0] t, input logic [1:0] tp);
        done = d; is_taken = tk; is_gate = gt; is_rfi = rf; null_next = nn;
        tgt_off = t; tgt_priv = tp; stall = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_fo = RV; m_fp = 0; m_bo = RV + 4; m_bp = 0; m_b = 0; m_n = 0; m_x = 0;
        repeat (3) @(negedge clk);
        cmp_state("R9");
        rst_n = 1'b1;
        @(negedge clk);
        cmp_state("R9");

        set_ev(1, 0, 0, 0, 0, 0, 0);              cycle("R2");
        set_ev(1, 1, 0, 0, 0, 32'h203, 2'd2);     cycle("R1");
        set_ev(1, 1, 0, 0, 0, 32'h400, 2'd0);     cycle("R6");
        set_ev(1, 0, 0, 0, 0, 0, 0);              cycle("R6");
        set_ev(1, 0, 0, 0, 0, 0, 0);              cycle("R6");
        set_ev(1, 1, 0, 0, 0, 32'h300, 2'd1);     cycle("R1");
        set_ev(1, 1, 1, 0, 0, 32'h500, 2'd3);     cycle("R5");
        set_ev(1, 0, 0, 0, 0, 0, 0);              cycle("R2");
        set_ev(1, 1, 1, 0, 0, 32'h600, 2'd3);     cycle("R5");
        set_ev(1, 0, 0, 0, 1, 0, 0);              cycle("R4");
        is_rfi = 1; is_taken = 1; is_gate = 1; null_next = 1; tgt_off = 32'h900;
        rfi_front_off = 32'h7000; rfi_back_off = 32'h8000; rfi_b = 1; rfi_x = 1;
        cycle("R3");
        set_ev(1, 1, 0, 0, 0, 32'hA00, 0); stall = 1; cycle("R8");
        set_ev(0, 1, 0, 1, 0, 32'hA00, 0);           cycle("R8");
        set_ev(1, 0, 0, 1, 0, 0, 0);
        rfi_front_off = 32'h1003; rfi_front_priv = 3; rfi_back_off = 32'h2002;
        rfi_back_priv = 1; rfi_b = 1; rfi_n = 0; rfi_x = 1;
        cycle("R7");
        set_ev(1, 0, 0, 0, 0, 0, 0);              cycle("R10");

        void'($urandom(32'd12345));
        for (int i = 0; i < 600; i++) begin
            done = ($urandom % 8) != 0;
            stall = ($urandom % 8) == 0;
            is_taken = $urandom % 2;
            is_gate = ($urandom % 4) == 0;
            is_rfi = ($urandom % 16) == 0;
            null_next = ($urandom % 4) == 0;
            tgt_off = $urandom; tgt_priv = 2'($urandom);
            rfi_front_off = $urandom; rfi_front_priv = 2'($urandom);
            rfi_back_off = $urandom; rfi_back_priv = 2'($urandom);
            rfi_b = $urandom % 2; rfi_n = $urandom % 2; rfi_x = $urandom % 2;
            cycle("RND");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule